// File: doc/BRIEF.md
# Fall-Through FIFO with Ready Handshakes

This block is a single-clock synchronous FIFO for 36-bit words. Its timing mode is fixed once after each reset. In fall-through mode the oldest stored word sits on the data output without any read request. An output-ready signal says a valid word is being presented, and an input-ready signal says the storage can take another word. In standard mode the block works as a conventional read-request FIFO. A read request moves the next word onto the output register on the following edge. The two ready outputs then serve as not-empty and not-full flags.

The mode comes from a select pin. The pin is sampled on the first rising edge after reset is released, and a low level picks fall-through mode. Until that edge both ready outputs stay low and all traffic is ignored. Storage depth is a power-of-two parameter with a default of 16. In fall-through mode the presenting output register adds one more word of holding capacity.

Top module: `ready_fifo`

## Requirements
- R1: While reset (active high, synchronous) is held, after at least one edge, inReady and outReady are 0 and rdData is all zeros.
- R2: On the first rising edge with reset low, the block samples modeSel: 0 selects fall-through mode and 1 selects standard mode. Before that edge inReady and outReady are 0, and a write presented in that cycle is discarded.
- R3: Once sampled, the mode does not change until the next reset, whatever later values modeSel takes.
- R4: In fall-through mode, outReady is 1 exactly when rdData holds a valid unread word. A word written into an empty FIFO appears on rdData with outReady high after the second rising edge that follows its write, with no read.
- R5: In fall-through mode, rdEn with outReady high consumes the presented word. On the same edge the next stored word is loaded, or outReady drops if none is stored. With no read, rdData holds still.
- R6: In fall-through mode, inReady is 1 exactly when the storage (DEPTH words, not counting the output register) has a free slot. The total capacity is therefore DEPTH+1 words.
- R7: In standard mode, rdData changes only on a read. A read with outReady high loads the oldest word into rdData on that edge. outReady is 1 exactly when at least one word is stored.
- R8: In standard mode, inReady is 1 exactly when fewer than DEPTH words are stored.
- R9: A write with inReady low and a read with no word available are ignored. They store nothing, lose nothing and leave rdData unchanged.
- R10: Words leave in the order they were accepted, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 1 | Mode select, sampled once after reset (0 = fall-through) |
| wrEn | input | 1 | Write request |
| wrData | input | 36 | Write data |
| rdEn | input | 1 | Read request |
| rdData | output | 36 | Output data register |
| inReady | output | 1 | Space available for a write |
| outReady | output | 1 | Valid word presented (fall-through) or not empty (standard) |

## Verification
Every result settles after a fixed number of rising edges from its stimulus. The ready outputs and the standard-mode data follow one edge after the write or read that changes them. A fall-through word reaches rdData two edges after being written into an empty FIFO: one edge to store it and one to load it. The bench drives inputs at the falling edge and advances a model built from the requirements by one edge. It compares all three outputs at the next falling edge, so each expected value is looked at exactly one edge after the inputs that produced it. Directed steps confirm the two-edge fall-through delay, discarded overflow writes and the ignored mode pin by checking ports at those counted edges.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/rfifo_ctrl.sv
module rfifo_ctrl import rfifo_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     modeSel,
  input  logic                     wrEn,
  input  logic                     rdEn,
  output fifoStrobe_t              strobe,
  output logic                     inReady,
  output logic                     outReady,
  output logic                     modeLocked,
  output logic                     fwftMode,
  output logic [$clog2(DEPTH):0]   fillCount
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic outValid;
  logic spaceFree;
  logic haveWord;
  logic popReq;

  always_comb begin
    spaceFree  = modeLocked && (fillCount != FULL_CNT);
    haveWord   = modeLocked && (fillCount != '0);
    popReq     = fwftMode ? (!outValid || rdEn) : rdEn;
    strobe.push = wrEn && spaceFree;
    strobe.pop  = haveWord && popReq;
    inReady    = spaceFree;
    outReady   = fwftMode ? outValid : haveWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeLocked <= 1'b0;
      fwftMode   <= 1'b0;
      fillCount  <= '0;
      outValid   <= 1'b0;
    end else begin
      if (!modeLocked) begin
        modeLocked <= 1'b1;
        fwftMode   <= !modeSel;
      end
      case ({strobe.push, strobe.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
      if (fwftMode) begin
        if (strobe.pop)  outValid <= 1'b1;
        else if (rdEn)   outValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rfifo_dpath.sv
module rfifo_dpath import rfifo_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  fifoStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop) begin
        rdPtr  <= rdPtr + 1'b1;
        rdData <= mem[rdPtr];
      end
    end
  end
endmodule

// File: rtl/ready_fifo.sv
module ready_fifo import rfifo_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             inReady,
  output logic             outReady
);
  localparam int AW = $clog2(DEPTH);

  fifoStrobe_t   strobe;
  logic          modeLocked;
  logic          fwftMode;
  logic [AW:0]   fillCount;

  rfifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rst(rst), .modeSel(modeSel), .wrEn(wrEn), .rdEn(rdEn),
    .strobe(strobe), .inReady(inReady), .outReady(outReady),
    .modeLocked(modeLocked), .fwftMode(fwftMode), .fillCount(fillCount)
  );

  rfifo_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uDpath (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/ready_fifo_chk.sv
module ready_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 36
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wrEn,
  input logic                   rdEn,
  input logic [WIDTH-1:0]       rdData,
  input logic                   inReady,
  input logic                   outReady,
  input logic                   modeLocked,
  input logic                   fwftMode,
  input logic [$clog2(DEPTH):0] fillCount
);
  // R2
  quiet_before_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !modeLocked |-> (!inReady && !outReady));

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    modeLocked |=> (modeLocked && $stable(fwftMode)));

  // R5
  fwft_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (modeLocked && fwftMode && outReady && !rdEn) |=> (outReady && $stable(rdData)));

  // R7
  std_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (modeLocked && !fwftMode && !rdEn) |=> $stable(rdData));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !inReady) |=> (fillCount <= $past(fillCount)));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (modeLocked && !fwftMode && !outReady && rdEn) |=> $stable(rdData));

  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fillCount <= ($clog2(DEPTH)+1)'(DEPTH));
endmodule

bind ready_fifo ready_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uChk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
  .inReady(inReady), .outReady(outReady), .modeLocked(modeLocked),
  .fwftMode(fwftMode), .fillCount(fillCount)
);

// File: tb/sim_ready_fifo.sv
module sim_ready_fifo;
  localparam int DEPTH = 16;
  localparam int WIDTH = 36;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, modeSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic inReady, outReady;

  ready_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .modeSel(modeSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .inReady(inReady), .outReady(outReady)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit mLocked, mFwft, mOv;
  logic [WIDTH-1:0] mRd;
  logic [WIDTH-1:0] q[$];
  logic [WIDTH-1:0] nextWord = 36'h100000000;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(string tag, string what, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic expIn, expOut;
    expIn  = mLocked && (q.size() < DEPTH);
    expOut = mFwft ? mOv : (mLocked && q.size() > 0);
    chk(mFwft ? "R6" : "R8", "inReady", {35'd0, inReady}, {35'd0, expIn});
    chk(mFwft ? "R4" : "R7", "outReady", {35'd0, outReady}, {35'd0, expOut});
    chk(mFwft ? "R5/R10" : "R7/R10", "rdData", rdData, mRd);
  endtask

  task automatic step(bit ms, bit we, bit re);
    int sz;
    bit acc;
    @(negedge clk);
    compare();
    modeSel = ms; wrEn = we; rdEn = re; wrData = nextWord;
    nextWord = nextWord + 36'd7;
    sz = q.size();
    acc = mLocked && (sz < DEPTH);
    if (mFwft) begin
      if (sz > 0 && (!mOv || re)) begin mRd = q.pop_front(); mOv = 1; end
      else if (re) mOv = 0;
    end else if (re && sz > 0) begin
      mRd = q.pop_front();
    end
    if (we && acc) q.push_back(wrData);
  endtask

  task automatic doReset(bit ms);
    @(negedge clk);
    rst = 1; modeSel = ms; wrEn = 0; rdEn = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "inReady in reset", {35'd0, inReady}, '0);
    chk("R1", "outReady in reset", {35'd0, outReady}, '0);
    chk("R1", "rdData in reset", rdData, '0);
    q.delete(); mLocked = 0; mFwft = 0; mOv = 0; mRd = '0;
    rst = 0; wrEn = 1; wrData = 36'hBADBADBAD;
    #1;
    // R2 nothing ready before the sampling edge
    chk("R2", "inReady before lock", {35'd0, inReady}, '0);
    chk("R2", "outReady before lock", {35'd0, outReady}, '0);
    mLocked = 1; mFwft = !ms;
  endtask

  task automatic runMode(bit ms);
    doReset(ms);
    // R4 fall-through of a single word, pin held opposite (R3)
    step(!ms, 1, 0);
    step(!ms, 0, 0);
    step(!ms, 0, 0);
    if (!ms) chk("R3/R4", "word fell through", {35'd0, outReady}, 36'd1);
    else     chk("R3/R7", "stored word flagged", {35'd0, outReady}, 36'd1);
    // fill past capacity (R6/R8/R9)
    for (int i = 0; i < DEPTH + 4; i++) step(i[0], 1, 0);
    // drain with surplus reads (R5/R7/R9)
    for (int i = 0; i < DEPTH + 4; i++) step(i[1], 0, 1);
    step(0, 0, 0);
    // R9 nothing extra was stored by the refused writes
    chk("R9", "empty after drain", {35'd0, outReady}, '0);
    // mixed traffic at several densities
    for (int d = 0; d < 4; d++) begin
      for (int i = 0; i < 120; i++) begin
        bit we, re;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        we = (lf[1:0] <= 2'(3 - d));
        re = (lf[3:2] <= 2'(d));
        step(lf[5], we, re);
      end
    end
    for (int i = 0; i < DEPTH + 4; i++) step(lf[i % 16], 0, 1);
    step(1, 0, 0);
  endtask

  initial begin
    runMode(1'b0);
    runMode(1'b1);
    runMode(1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule